// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point words (1 sign bit, 8-bit exponent with bias 127, 23-bit stored fraction, value (-1)^s x 1.F x 2^(E-127)). It returns one correctly rounded 32-bit result one clock after the operands are presented. The arithmetic path puts back the implicit leading one and shifts the significand of the smaller-magnitude operand right. Bits shifted out are kept as guard, round and sticky. The path then adds or subtracts, normalises, rounds to nearest with ties to even, renormalises on a rounding carry and packs the word.

An operation select turns the block into a subtractor by inverting the sign of the second operand before it decides between effective addition and subtraction. Zero, infinity and NaN operands follow fixed rules. Denormal operands are read as zero, and results too small to normalise are flushed to a signed zero. Two flags mark overflow and underflow of the arithmetic path.

Top module: `fp_add_sp`

## Requirements
- R1: With `in_valid` high at a rising edge, the result for those operands appears on `result` with `out_valid` high after that edge. With `in_valid` low, `out_valid` is low after the edge. For two normal operands of equal sign with `op_sub` low, `result` is their sum rounded to 24 significant bits.
- R2: With `op_sub` high the block returns `op_a - op_b`: the sign bit (bit 31) of `op_b` is inverted before the operation is chosen. The sign of a nonzero difference is the sign of the larger-magnitude operand.
- R3: Rounding is to nearest, ties to even. The kept 24-bit significand is incremented when guard AND (kept LSB OR round OR sticky), where sticky is the OR of every bit shifted out below the round bit.
- R4: Cancellation in a subtraction is normalised by left shifts, and the exponent drops by one per shift. An exact zero difference of finite nonzero operands gives +0 (0x00000000) with both flags low.
- R5: A rounding increment that carries out of the significand shifts it right once more and adds one to the exponent.
- R6: If the exponent after rounding is 255 or more, the result is infinity with the result sign (0x7F800000 or 0xFF800000) and `ovf` is 1.
- R7: If the biased exponent of the normalised result before rounding is below 1, the result is zero with the result sign and `unf` is 1.
- R8: An operand with exponent field 0 is zero whatever its fraction. If both operands are zero, the result is a zero whose sign is the AND of the two signs (the sign of `op_b` inverted when subtracting). If only one operand is zero, the result is the other operand, sign-adjusted when it is `op_b`.
- R9: A NaN operand (exponent 255, fraction nonzero), or infinities of opposite effective sign, give the quiet NaN 0x7FC00000. Otherwise an infinite operand gives infinity with that operand's effective sign. Both flags are low on these paths.
- R10: While `rst_n` is low, `out_valid`, `result`, `ovf` and `unf` are all 0.
- R11: `ovf` and `unf` are never high together, and both are 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1: a - b, 0: a + b |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 32 | Rounded sum or difference |
| ovf | output | 1 | Result overflowed to infinity |
| unf | output | 1 | Result underflowed to zero |

## Verification
The bench targets these cases:
- Exact ties one half-ulp from both neighbours, with an even and with an odd kept LSB. A design that rounds half-up or truncates picks the wrong neighbour.
- Sums just above a tie, where only the sticky bit breaks it. A design that drops shifted-out bits rounds down.
- Carry-out from rounding at 0x3FFFFFFF and at the largest finite value. A design that misses the carry gives a wrong exponent or fails to raise overflow.
- Subtraction of near-equal values, where a wrong leading-zero count gives an exponent that is off by the miscounted shift.
- Exact cancellation, which must give +0.
- Differences that fall below the smallest normal, which must flush to zero and raise underflow.
- Denormal, zero, infinity and NaN operand combinations, where a wrong sign rule shows up directly in bit 31.

Thousands of random operand pairs, biased toward close exponents, are compared with an exact wide-integer model.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  localparam int unsigned FP_EXP_W  = 8;
  localparam int unsigned FP_FRAC_W = 23;

  typedef enum logic [2:0] {
    PATH_ARITH,
    PATH_NAN,
    PATH_INF_A,
    PATH_INF_B,
    PATH_ZERO_BOTH,
    PATH_ZERO_A,
    PATH_ZERO_B
  } fp_path_e;

  // Chooses which result source applies, by priority of operand classes.
  function automatic fp_path_e pick_path(
    input logic a_nan, input logic b_nan,
    input logic a_inf, input logic b_inf,
    input logic a_zero, input logic b_zero,
    input logic signs_differ
  );
    if (a_nan || b_nan || (a_inf && b_inf && signs_differ)) return PATH_NAN;
    if (a_inf)               return PATH_INF_A;
    if (b_inf)               return PATH_INF_B;
    if (a_zero && b_zero)    return PATH_ZERO_BOTH;
    if (a_zero)              return PATH_ZERO_A;
    if (b_zero)              return PATH_ZERO_B;
    return PATH_ARITH;
  endfunction

endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]      word,
  output logic              sgn,
  output logic [EXP_W-1:0]  expo,
  output logic [FRAC_W:0]   sig,
  output logic              is_zero,
  output logic              is_inf,
  output logic              is_nan
);
  logic [FRAC_W-1:0] frac;
  logic              exp_max;

  assign sgn     = word[W-1];
  assign expo    = word[W-2:FRAC_W];
  assign frac    = word[FRAC_W-1:0];
  assign exp_max = &expo;
  // Exponent 0 covers zero and denormals: both are read as zero.
  assign is_zero = (expo == '0);
  assign is_inf  = exp_max && (frac == '0);
  assign is_nan  = exp_max && (frac != '0);
  assign sig     = {!is_zero, frac};
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned SW    = FRAC_W + 4
) (
  input  logic              a_sgn,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [FRAC_W:0]   a_sig,
  input  logic              b_sgn,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [FRAC_W:0]   b_sig,
  output logic              big_sgn,
  output logic [EXP_W-1:0]  big_exp,
  output logic [EXP_W-1:0]  small_exp,
  output logic [SW-1:0]     big_ext,
  output logic [SW-1:0]     small_ext,
  output logic              eff_sub
);
  logic              a_ge;
  logic [FRAC_W:0]   small_sig;
  logic [EXP_W-1:0]  diff;
  logic [EXP_W-1:0]  shamt;
  logic [2*SW-1:0]   wide;
  logic              sticky;

  assign a_ge      = {a_exp, a_sig} >= {b_exp, b_sig};
  assign big_sgn   = a_ge ? a_sgn : b_sgn;
  assign big_exp   = a_ge ? a_exp : b_exp;
  assign small_exp = a_ge ? b_exp : a_exp;
  assign small_sig = a_ge ? b_sig : a_sig;
  assign big_ext   = {(a_ge ? a_sig : b_sig), 3'b000};
  assign eff_sub   = a_sgn ^ b_sgn;

  // Shifts of SW or more push every bit below the round position.
  assign diff   = big_exp - small_exp;
  assign shamt  = (diff > EXP_W'(SW)) ? EXP_W'(SW) : diff;
  assign wide   = {small_sig, 3'b000, {SW{1'b0}}} >> shamt;
  assign sticky = |wide[SW-1:0];
  assign small_ext = wide[2*SW-1:SW] | {{(SW-1){1'b0}}, sticky};
endmodule

// File: rtl/fpadd_normround.sv
module fpadd_normround #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W,
  localparam int unsigned SW    = FRAC_W + 4,
  localparam int unsigned LZW   = $clog2(SW + 1),
  localparam int unsigned EW2   = EXP_W + 2,
  localparam int unsigned EMAX  = (1 << EXP_W) - 1
) (
  input  logic              sgn,
  input  logic              eff_sub,
  input  logic [EXP_W-1:0]  big_exp,
  input  logic [SW-1:0]     big_ext,
  input  logic [SW-1:0]     small_ext,
  output logic [W-1:0]      packed_out,
  output logic              ovf,
  output logic              unf,
  output logic              exact_zero,
  output logic [SW-1:0]     norm_sig
);
  logic [SW:0]             sum;
  logic [LZW-1:0]          lz;
  logic signed [EW2-1:0]   nexp;
  logic                    rnd_inc;
  logic [FRAC_W+1:0]       rsum;
  logic                    rnd_carry;
  logic signed [EW2-1:0]   rexp;
  logic [FRAC_W-1:0]       rfrac;

  function automatic logic [LZW-1:0] lead_zeros(input logic [SW-1:0] v);
    logic [LZW-1:0] n;
    logic           seen;
    n    = '0;
    seen = 1'b0;
    for (int i = SW - 1; i >= 0; i--) begin
      if (!seen) begin
        if (v[i]) seen = 1'b1;
        else      n    = n + 1'b1;
      end
    end
    return n;
  endfunction

  function automatic logic round_up(input logic [SW-1:0] s);
    // s[3] kept LSB, s[2] guard, s[1] round, s[0] sticky
    return s[2] & (s[3] | s[1] | s[0]);
  endfunction

  assign sum = eff_sub ? ({1'b0, big_ext} - {1'b0, small_ext})
                       : ({1'b0, big_ext} + {1'b0, small_ext});
  assign exact_zero = (sum == '0);
  assign lz = lead_zeros(sum[SW-1:0]);

  always_comb begin
    if (sum[SW]) begin
      norm_sig = {sum[SW:2], sum[1] | sum[0]};
      nexp     = $signed({2'b00, big_exp}) + $signed(EW2'(1));
    end else begin
      norm_sig = sum[SW-1:0] << lz;
      nexp     = $signed({2'b00, big_exp}) - $signed({{(EW2-LZW){1'b0}}, lz});
    end
  end

  assign rnd_inc   = round_up(norm_sig);
  assign rsum      = {1'b0, norm_sig[SW-1:3]} + {{(FRAC_W+1){1'b0}}, rnd_inc};
  assign rnd_carry = rsum[FRAC_W+1];
  assign rexp      = nexp + $signed({{(EW2-1){1'b0}}, rnd_carry});
  assign rfrac     = rnd_carry ? rsum[FRAC_W:1] : rsum[FRAC_W-1:0];

  assign unf = !exact_zero && (nexp < $signed(EW2'(1)));
  assign ovf = !exact_zero && !unf && (rexp >= $signed(EW2'(EMAX)));

  always_comb begin
    if (exact_zero)  packed_out = '0;
    else if (unf)    packed_out = {sgn, {(W-1){1'b0}}};
    else if (ovf)    packed_out = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else             packed_out = {sgn, rexp[EXP_W-1:0], rfrac};
  end
endmodule

// File: rtl/fp_add_sp.sv
module fp_add_sp
  import fpadd_pkg::*;
#(
  parameter int unsigned EXP_W  = FP_EXP_W,
  parameter int unsigned FRAC_W = FP_FRAC_W,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W,
  localparam int unsigned SW    = FRAC_W + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic          op_sub,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          ovf,
  output logic          unf
);
  logic              a_sgn, b_sgn, b_sgn_eff;
  logic [EXP_W-1:0]  a_exp, b_exp;
  logic [FRAC_W:0]   a_sig, b_sig;
  logic              a_zero, a_inf, a_nan, b_zero, b_inf, b_nan;

  fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_a (
    .word(op_a), .sgn(a_sgn), .expo(a_exp), .sig(a_sig),
    .is_zero(a_zero), .is_inf(a_inf), .is_nan(a_nan));

  fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_b (
    .word(op_b), .sgn(b_sgn), .expo(b_exp), .sig(b_sig),
    .is_zero(b_zero), .is_inf(b_inf), .is_nan(b_nan));

  assign b_sgn_eff = b_sgn ^ op_sub;

  logic              big_sgn, eff_sub;
  logic [EXP_W-1:0]  big_exp, small_exp;
  logic [SW-1:0]     big_ext, small_ext;

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .a_sgn(a_sgn), .a_exp(a_exp), .a_sig(a_sig),
    .b_sgn(b_sgn_eff), .b_exp(b_exp), .b_sig(b_sig),
    .big_sgn(big_sgn), .big_exp(big_exp), .small_exp(small_exp),
    .big_ext(big_ext), .small_ext(small_ext), .eff_sub(eff_sub));

  logic [W-1:0]   arith_word;
  logic           arith_ovf, arith_unf, arith_zero;
  logic [SW-1:0]  norm_sig;

  fpadd_normround #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_normround (
    .sgn(big_sgn), .eff_sub(eff_sub), .big_exp(big_exp),
    .big_ext(big_ext), .small_ext(small_ext),
    .packed_out(arith_word), .ovf(arith_ovf), .unf(arith_unf),
    .exact_zero(arith_zero), .norm_sig(norm_sig));

  fp_path_e      path;
  logic [W-1:0]  nxt_word;
  logic          nxt_ovf, nxt_unf;

  assign path = pick_path(a_nan, b_nan, a_inf, b_inf, a_zero, b_zero,
                          a_sgn ^ b_sgn_eff);

  always_comb begin
    nxt_ovf = 1'b0;
    nxt_unf = 1'b0;
    unique case (path)
      PATH_NAN:       nxt_word = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
      PATH_INF_A:     nxt_word = {a_sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      PATH_INF_B:     nxt_word = {b_sgn_eff, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      PATH_ZERO_BOTH: nxt_word = {a_sgn & b_sgn_eff, {(W-1){1'b0}}};
      PATH_ZERO_A:    nxt_word = {b_sgn_eff, op_b[W-2:0]};
      PATH_ZERO_B:    nxt_word = op_a;
      default: begin
        nxt_word = arith_word;
        nxt_ovf  = arith_ovf;
        nxt_unf  = arith_unf;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_word;
        ovf    <= nxt_ovf;
        unf    <= nxt_unf;
      end else begin
        ovf    <= 1'b0;
        unf    <= 1'b0;
      end
    end
  end

  // R1: one-cycle latency of the valid strobe
  a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R11: flags exclusive and quiet when idle
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
  a_r11_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!ovf && !unf));
  // R2: aligner always hands the larger exponent to the adder
  a_r2_align_order: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && path == PATH_ARITH) |-> (big_exp >= small_exp));
  // R4: normaliser leaves a leading one unless the difference vanished
  a_r4_norm_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && path == PATH_ARITH && !arith_zero) |-> norm_sig[SW-1]);
  // R6: overflow result is a signed infinity
  a_r6_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  // R7: underflow result is a signed zero
  a_r7_unf_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (result[W-2:0] == '0));
endmodule

// File: tb/test_fp_add_sp.sv
module test_fp_add_sp;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        op_sub = 1'b0;
  logic        out_valid, ovf, unf;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  logic        pend_valid = 1'b0;
  logic [33:0] pend_exp = '0;
  string       pend_tag = "";

  fp_add_sp i_fp_add_sp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Exact model: operands become wide integers, the sum is exact, then rounded.
  function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic sub);
    logic sa, sb;
    int ea, eb, emin, p, e, sh;
    logic [287:0] ma, mb, m, keep, rem, half;
    logic sgn;
    sa = a[31];
    sb = b[31] ^ sub;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return {2'b00, 32'h7FC00000};
    if (ea == 255 && eb == 255 && sa != sb) return {2'b00, 32'h7FC00000};
    if (ea == 255) return {2'b00, sa, 31'h7F800000};
    if (eb == 255) return {2'b00, sb, 31'h7F800000};
    if (ea == 0 && eb == 0) return {2'b00, sa & sb, 31'h0};
    if (ea == 0) return {2'b00, sb, b[30:0]};
    if (eb == 0) return {2'b00, a};
    emin = (ea < eb) ? ea : eb;
    ma = {264'd0, 1'b1, a[22:0]} << (ea - emin);
    mb = {264'd0, 1'b1, b[22:0]} << (eb - emin);
    if (sa == sb) begin m = ma + mb; sgn = sa; end
    else if (ma >= mb) begin m = ma - mb; sgn = sa; end
    else begin m = mb - ma; sgn = sb; end
    if (m == 0) return 34'd0;
    p = -1;
    for (int i = 287; i >= 0; i--) if (p < 0 && m[i]) p = i;
    e = emin + p - 23;
    if (e < 1) return {2'b01, sgn, 31'h0};
    if (p > 23) begin
      sh = p - 23;
      keep = m >> sh;
      rem  = m & ((288'd1 << sh) - 288'd1);
      half = 288'd1 << (sh - 1);
      if (rem > half || (rem == half && keep[0])) keep = keep + 288'd1;
    end else begin
      keep = m << (23 - p);
    end
    if (keep[24]) begin keep = keep >> 1; e = e + 1; end
    if (e >= 255) return {2'b10, sgn, 31'h7F800000};
    return {2'b00, sgn, e[7:0], keep[22:0]};
  endfunction

  task automatic check_out();
    checks++;
    if (pend_valid) begin
      if (out_valid !== 1'b1 || {ovf, unf, result} !== pend_exp) begin
        errors++;
        $display("FAIL %s: got v=%b ovf=%b unf=%b res=%h, expected v=1 ovf=%b unf=%b res=%h",
                 pend_tag, out_valid, ovf, unf, result, pend_exp[33], pend_exp[32], pend_exp[31:0]);
      end
    end else begin
      if (out_valid !== 1'b0 || ovf !== 1'b0 || unf !== 1'b0) begin
        errors++;
        $display("FAIL R11 idle: got v=%b ovf=%b unf=%b, expected v=0 ovf=0 unf=0",
                 out_valid, ovf, unf);
      end
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic s, input string tag);
    @(negedge clk);
    check_out();
    in_valid = v;
    op_a = a;
    op_b = b;
    op_sub = s;
    pend_valid = v;
    pend_exp = model(a, b, s);
    pend_tag = tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 32'h0 || ovf !== 1'b0 || unf !== 1'b0) begin
      errors++;
      $display("FAIL R10: got v=%b res=%h ovf=%b unf=%b, expected all 0", out_valid, result, ovf, unf);
    end
    rst_n = 1'b1;
    // R1 plain sums
    step(1, 32'h3F800000, 32'h3F800000, 0, "R1");
    step(1, 32'h3F000000, 32'h40300000, 0, "R1");
    step(0, 32'h0, 32'h0, 0, "R1");
    // R2 subtraction sign handling
    step(1, 32'h40400000, 32'h3F800000, 1, "R2");
    step(1, 32'h3F800000, 32'h40400000, 1, "R2");
    // R3 ties and sticky
    step(1, 32'h3F800000, 32'h33800000, 0, "R3");
    step(1, 32'h3F800001, 32'h33800000, 0, "R3");
    step(1, 32'h3F800000, 32'h33800001, 0, "R3");
    // R4 cancellation and exact zero
    step(1, 32'h3F800001, 32'h3F800000, 1, "R4");
    step(1, 32'h40490FDB, 32'h40490FDB, 1, "R4");
    step(1, 32'hC0490FDB, 32'h40490FDB, 0, "R4");
    // R5 rounding carry
    step(1, 32'h3FFFFFFF, 32'h33800000, 0, "R5");
    // R6 overflow
    step(1, 32'h7F7FFFFF, 32'h7F7FFFFF, 0, "R6");
    step(1, 32'hFF7FFFFF, 32'hFF7FFFFF, 0, "R6");
    step(1, 32'h7F7FFFFF, 32'h73000000, 0, "R6");
    // R7 underflow
    step(1, 32'h00800001, 32'h00800000, 1, "R7");
    step(1, 32'h80800001, 32'h80800000, 1, "R7");
    // R8 zeros and denormals
    step(1, 32'h00000001, 32'h3F800000, 0, "R8");
    step(1, 32'h80000000, 32'h80000000, 0, "R8");
    step(1, 32'h80000000, 32'h00000000, 1, "R8");
    step(1, 32'h00000000, 32'h80000000, 0, "R8");
    step(1, 32'h00000000, 32'h3F800000, 1, "R8");
    // R9 specials
    step(1, 32'h7FC00001, 32'h3F800000, 0, "R9");
    step(1, 32'h7F800000, 32'h7F800000, 1, "R9");
    step(1, 32'h7F800000, 32'hFF800000, 0, "R9");
    step(1, 32'h7F800000, 32'h40A00000, 0, "R9");
    step(1, 32'h3F800000, 32'h7F800000, 1, "R9");
    step(0, 32'h0, 32'h0, 0, "R11");
    // R1/R2 random, full range and close exponents
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (k % 2 == 1) rb[30:23] = ra[30:23] + 8'($urandom_range(0, 3)) - 8'd1;
      step(1, ra, rb, k[2], k[2] ? "R2" : "R1");
      if (k % 97 == 0) step(0, ra, rb, 0, "R11");
    end
    step(0, 32'h0, 32'h0, 0, "R1");
    @(negedge clk);
    check_out();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule